// File: doc/BRIEF.md
# OSD Icon Screen Sequencer and Highlight Timer

This block is the field-rate control logic of a small on-screen display overlay. It watches the vertical sync input and counts video fields. From that count it decides which of the three screens of the selected icon set is shown. In automatic mode it rotates through the screens at a programmable pace. A software-set override can pin one screen instead.

The block also holds the three-bit display control code. That code switches the overlay off, switches it on with plain colours, or switches it on with one of four button highlights (up, down, plus, minus). A highlight is temporary. It falls back to the plain on code by itself once a fixed number of fields have passed.

The pixel generator downstream takes three things from this block:
- the icon address, formed from the set select and the screen index;
- the overlay enable;
- a one-hot highlight vector.

Top module: `osd_icon_seq`

## Requirements
- R1: A field is counted once per rising edge of `vsync`. Holding `vsync` high for several clocks counts as a single field.
- R2: In automatic mode (`hold_sel` = 00), `screen_idx` steps 0, 1, 2, 0, … and repeats indefinitely. Each screen is shown for `alt_period` × 8 fields.
- R3: An `alt_period` of 0 acts as 1, so each screen is shown for 8 fields.
- R4: `hold_sel` values 01, 10 and 11 pin `screen_idx` to 0, 1 and 2 respectively. The pin takes effect in the same cycle, and fields do not move it.
- R5: When `hold_sel` returns to 00, rotation restarts at screen 0 with a full dwell period.
- R6: Control code 000 drives `osd_on` low. Codes 001, 110 and 111 drive `osd_on` high with `hl_sel` all zero, and these codes never revert.
- R7: Codes 010, 011, 100 and 101 drive `osd_on` high and set `hl_sel` bit 0 (up), bit 1 (down), bit 2 (plus) or bit 3 (minus) respectively. `hl_sel` is never more than one-hot.
- R8: A highlight code stays in place for 31 fields after it is written. On the 32nd field it becomes 001, and `ctrl_code` reads back 001.
- R9: Writing any code through `ctrl_wr` replaces the current code at once and restarts the 32-field highlight count.
- R10: `icon_addr` equals {`icon_set`, `screen_idx`}, with the set select in the upper four bits.
- R11: After reset, `screen_idx` is 0, `ctrl_code` is 000 and `osd_on` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Vertical sync level; its rising edge marks a field |
| alt_period | input | 4 | Screen dwell time in units of 8 fields |
| hold_sel | input | 2 | 00 selects automatic rotation; 01/10/11 pin screen 0/1/2 |
| icon_set | input | 4 | Selected icon set, 0 to 15 |
| ctrl_wr | input | 1 | One-cycle strobe that loads `ctrl_wdata` |
| ctrl_wdata | input | 3 | New display control code |
| screen_idx | output | 2 | Current screen, 0 to 2 |
| icon_addr | output | 6 | Icon set and screen combined |
| ctrl_code | output | 3 | Current control code (readback) |
| osd_on | output | 1 | Overlay enable |
| hl_sel | output | 4 | One-hot highlight: up, down, plus, minus |

## Verification
Some properties are checked by the embedded assertions on every cycle:
- one tick per sync edge;
- the counters stay frozen between fields;
- the screen index only ever moves to its successor or to 0, and never reaches 3;
- an override leaves the rotation state cleared;
- a code change without a write can only be a revert to 001;
- the highlight count sits at zero for non-highlight codes;
- the highlight vector is at most one-hot and dark when the overlay is off.

Exact timing can only be shown by the bench's scenarios: the 8-field and 16-field dwell lengths, the 32nd-field revert, and the restart of that count by a second write. The same holds for a held `vsync` counting once and for the fixed screen chosen by each override value.

// File: rtl/osd_seq_pkg.sv
package osd_seq_pkg;

  typedef enum logic [2:0] {
    CODE_OFF   = 3'd0,
    CODE_ON    = 3'd1,
    CODE_UP    = 3'd2,
    CODE_DOWN  = 3'd3,
    CODE_PLUS  = 3'd4,
    CODE_MINUS = 3'd5,
    CODE_ON_A  = 3'd6,
    CODE_ON_B  = 3'd7
  } ctrl_code_e;

  localparam int unsigned HL_KINDS = 4;
  localparam logic [2:0] HL_FIRST = 3'd2;

  function automatic logic code_is_hl(input logic [2:0] c);
    return (c >= HL_FIRST) && (c < HL_FIRST + 3'(HL_KINDS));
  endfunction

endpackage

// File: rtl/osd_field_edge.sv
module osd_field_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  output logic field_tick
);
  logic vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= vsync;
  end

  assign field_tick = vsync & ~vs_q;

  // R1: a held sync level yields one tick only
  assert_single_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    field_tick |=> !field_tick);

endmodule

// File: rtl/osd_screen_seq.sv
module osd_screen_seq #(
  parameter int unsigned PERIOD_W  = 4,
  parameter int unsigned STEP_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                field_tick,
  input  logic [PERIOD_W-1:0] alt_period,
  input  logic [1:0]          hold_sel,
  output logic [1:0]          screen_idx
);
  localparam int unsigned SUB_W = (STEP_LOG2 > 0) ? STEP_LOG2 : 1;
  localparam logic [1:0]  LAST_SCREEN = 2'd2;

  logic [SUB_W-1:0]    sub_q, sub_d;
  logic [PERIOD_W-1:0] step_q, step_d, last_step;
  logic [1:0]          scr_q, scr_d;
  logic                hold_on, sub_wrap, step_wrap, upd_en;

  assign hold_on   = (hold_sel != 2'd0);
  assign last_step = (alt_period == '0) ? '0 : alt_period - 1'b1;
  assign sub_wrap  = &sub_q;
  assign step_wrap = (step_q >= last_step);
  assign upd_en    = hold_on | field_tick;

  always_comb begin
    sub_d  = sub_q;
    step_d = step_q;
    scr_d  = scr_q;
    if (hold_on) begin
      sub_d  = '0;
      step_d = '0;
      scr_d  = 2'd0;
    end else if (field_tick) begin
      sub_d = sub_q + 1'b1;
      if (sub_wrap) begin
        if (step_wrap) begin
          step_d = '0;
          scr_d  = (scr_q == LAST_SCREEN) ? 2'd0 : scr_q + 2'd1;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      step_q <= '0;
      scr_q  <= 2'd0;
    end else if (upd_en) begin
      sub_q  <= sub_d;
      step_q <= step_d;
      scr_q  <= scr_d;
    end
  end

  assign screen_idx = hold_on ? (hold_sel - 2'd1) : scr_q;

  // R2: rotation only advances to the successor or wraps to 0
  assert_step_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_q != $past(scr_q)) |-> (scr_q == 2'd0 || scr_q == $past(scr_q) + 2'd1));
  // R2: screen 3 never appears
  assert_screen_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scr_q != 2'd3);
  // R1: counters frozen between fields
  assert_quiet_between_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_tick && !hold_on) |=> ($stable(sub_q) && $stable(step_q)));
  // R5: override leaves rotation cleared for a fresh start
  assert_hold_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_on |=> (scr_q == 2'd0 && step_q == '0 && sub_q == '0));

endmodule

// File: rtl/osd_hl_timer.sv
module osd_hl_timer
  import osd_seq_pkg::*;
#(
  parameter int unsigned HL_FIELDS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       field_tick,
  input  logic       ctrl_wr,
  input  logic [2:0] ctrl_wdata,
  output logic [2:0] ctrl_code
);
  localparam int unsigned CNT_W = (HL_FIELDS > 1) ? $clog2(HL_FIELDS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HL_FIELDS - 1);

  logic [2:0]       code_q, code_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_hl, upd_en;

  assign is_hl  = code_is_hl(code_q);
  assign upd_en = ctrl_wr | (field_tick & is_hl);

  always_comb begin
    code_d = code_q;
    cnt_d  = cnt_q;
    if (ctrl_wr) begin
      code_d = ctrl_wdata;
      cnt_d  = '0;
    end else if (field_tick && is_hl) begin
      if (cnt_q == CNT_LAST) begin
        code_d = CODE_ON;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_OFF;
      cnt_q  <= '0;
    end else if (upd_en) begin
      code_q <= code_d;
      cnt_q  <= cnt_d;
    end
  end

  assign ctrl_code = code_q;

  // R8: a change without a write can only be the revert to plain on
  assert_revert_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((code_q != $past(code_q)) && !$past(ctrl_wr)) |-> (code_q == CODE_ON));
  // R9: count rests at zero when no highlight is pending
  assert_cnt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_hl && !ctrl_wr) |=> (cnt_q == '0));

endmodule

// File: rtl/osd_icon_seq.sv
module osd_icon_seq
  import osd_seq_pkg::*;
#(
  parameter int unsigned PERIOD_W  = 4,
  parameter int unsigned STEP_LOG2 = 3,
  parameter int unsigned HL_FIELDS = 32,
  parameter int unsigned SET_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vsync,
  input  logic [PERIOD_W-1:0]  alt_period,
  input  logic [1:0]           hold_sel,
  input  logic [SET_W-1:0]     icon_set,
  input  logic                 ctrl_wr,
  input  logic [2:0]           ctrl_wdata,
  output logic [1:0]           screen_idx,
  output logic [SET_W+1:0]     icon_addr,
  output logic [2:0]           ctrl_code,
  output logic                 osd_on,
  output logic [HL_KINDS-1:0]  hl_sel
);
  logic field_tick;

  osd_field_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync      (vsync),
    .field_tick (field_tick)
  );

  osd_screen_seq #(.PERIOD_W(PERIOD_W), .STEP_LOG2(STEP_LOG2)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .field_tick (field_tick),
    .alt_period (alt_period),
    .hold_sel   (hold_sel),
    .screen_idx (screen_idx)
  );

  osd_hl_timer #(.HL_FIELDS(HL_FIELDS)) u_hl (
    .clk        (clk),
    .rst_n      (rst_n),
    .field_tick (field_tick),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_code  (ctrl_code)
  );

  assign icon_addr = {icon_set, screen_idx};
  assign osd_on    = (ctrl_code != CODE_OFF);

  for (genvar i = 0; i < HL_KINDS; i++) begin : g_hl
    assign hl_sel[i] = (ctrl_code == HL_FIRST + 3'(i));
  end

  // R7: highlight vector never more than one-hot
  assert_hl_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hl_sel));
  // R6: an off display shows no highlight
  assert_off_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !osd_on |-> (hl_sel == '0));

endmodule

// File: tb/osd_icon_seq_tb_top.sv
`timescale 1ns/1ps
module osd_icon_seq_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, vsync, ctrl_wr;
  logic [3:0] alt_period, icon_set;
  logic [1:0] hold_sel;
  logic [2:0] ctrl_wdata;
  logic [1:0] screen_idx;
  logic [5:0] icon_addr;
  logic [2:0] ctrl_code;
  logic       osd_on;
  logic [3:0] hl_sel;

  osd_icon_seq dut_i (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .alt_period(alt_period),
    .hold_sel(hold_sel), .icon_set(icon_set), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .screen_idx(screen_idx), .icon_addr(icon_addr),
    .ctrl_code(ctrl_code), .osd_on(osd_on), .hl_sel(hl_sel)
  );

  typedef struct {
    int    kind;
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  event  chk_ev;

  localparam int K_SCR = 0, K_CODE = 1, K_OSD = 2, K_HL = 3, K_ADDR = 4;

  function automatic int observe(int kind);
    case (kind)
      K_SCR:   return int'(screen_idx);
      K_CODE:  return int'(ctrl_code);
      K_OSD:   return int'(osd_on);
      K_HL:    return int'(hl_sel);
      default: return int'(icon_addr);
    endcase
  endfunction

  // monitor: pops expected items and compares once outputs are settled
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (q.size() > 0) begin
        item_t it;
        int    act;
        it  = q.pop_front();
        act = observe(it.kind);
        total++;
        if (act != it.exp) begin
          bad++;
          $display("FAIL %s: actual=%0d expected=%0d", it.tag, act, it.exp);
        end
      end
    end
  end

  // driver side: pushes an expectation and hands it to the monitor
  task automatic expect_val(int kind, int exp, string tag);
    q.push_back('{kind: kind, exp: exp, tag: tag});
    ->chk_ev;
    #2;
  endtask

  task automatic fields(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) vsync = 1'b1;
      @(negedge clk) vsync = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic write_code(logic [2:0] c);
    @(negedge clk);
    ctrl_wr    = 1'b1;
    ctrl_wdata = c;
    @(negedge clk);
    ctrl_wr    = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    vsync      = 1'b0;
    ctrl_wr    = 1'b0;
    ctrl_wdata = 3'd0;
    alt_period = 4'd1;
    hold_sel   = 2'd0;
    icon_set   = 4'hA;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    expect_val(K_SCR, 0, "R11 screen after reset");
    expect_val(K_CODE, 0, "R11 code after reset");
    expect_val(K_OSD, 0, "R11 osd after reset");
    expect_val(K_ADDR, 40, "R10 addr set A screen 0");

    // R1: a long sync pulse counts once
    @(negedge clk) vsync = 1'b1;
    repeat (5) @(negedge clk);
    vsync = 1'b0;
    @(negedge clk);
    fields(6);
    expect_val(K_SCR, 0, "R1 held vsync counted once (7 fields)");
    fields(1);
    expect_val(K_SCR, 1, "R2 advance after 8 fields");
    fields(8);
    expect_val(K_SCR, 2, "R2 screen 2 after 16 fields");
    expect_val(K_ADDR, 42, "R10 addr set A screen 2");
    fields(8);
    expect_val(K_SCR, 0, "R2 wrap to screen 0");

    // R3: period zero behaves as one
    alt_period = 4'd0;
    fields(7);
    expect_val(K_SCR, 0, "R3 period 0 holds 7 fields");
    fields(1);
    expect_val(K_SCR, 1, "R3 period 0 steps at 8 fields");

    // R2: period two gives 16 fields per screen
    alt_period = 4'd2;
    fields(15);
    expect_val(K_SCR, 1, "R2 period 2 holds 15 fields");
    fields(1);
    expect_val(K_SCR, 2, "R2 period 2 steps at 16 fields");

    // R4: overrides
    hold_sel = 2'd3;
    expect_val(K_SCR, 2, "R4 hold 11 -> screen 2");
    hold_sel = 2'd1;
    expect_val(K_SCR, 0, "R4 hold 01 -> screen 0");
    fields(10);
    expect_val(K_SCR, 0, "R4 hold ignores fields");
    hold_sel = 2'd2;
    expect_val(K_SCR, 1, "R4 hold 10 -> screen 1");
    fields(9);
    expect_val(K_SCR, 1, "R4 hold 10 ignores fields");

    // R5: release restarts at screen 0
    alt_period = 4'd1;
    @(negedge clk) hold_sel = 2'd0;
    expect_val(K_SCR, 0, "R5 release starts at screen 0");
    fields(7);
    expect_val(K_SCR, 0, "R5 full dwell after release");
    fields(1);
    expect_val(K_SCR, 1, "R5 step after 8 fields");

    // R6 / R7: code decode
    write_code(3'd0);
    expect_val(K_OSD, 0, "R6 code 000 off");
    expect_val(K_HL, 0, "R6 code 000 no highlight");
    write_code(3'd1);
    expect_val(K_OSD, 1, "R6 code 001 on");
    expect_val(K_HL, 0, "R6 code 001 no highlight");
    write_code(3'd2);
    expect_val(K_HL, 1, "R7 up -> bit 0");
    write_code(3'd3);
    expect_val(K_HL, 2, "R7 down -> bit 1");
    write_code(3'd4);
    expect_val(K_HL, 4, "R7 plus -> bit 2");
    write_code(3'd5);
    expect_val(K_HL, 8, "R7 minus -> bit 3");
    expect_val(K_OSD, 1, "R7 highlight keeps osd on");

    // R8: revert after 32 fields
    fields(31);
    expect_val(K_CODE, 5, "R8 highlight held 31 fields");
    fields(1);
    expect_val(K_CODE, 1, "R8 reverted to 001");
    expect_val(K_HL, 0, "R8 highlight cleared");

    // R9: rewrite restarts the count
    write_code(3'd4);
    fields(20);
    write_code(3'd3);
    fields(31);
    expect_val(K_CODE, 3, "R9 restarted count still held");
    fields(1);
    expect_val(K_CODE, 1, "R9 revert 32 fields after rewrite");

    // R6: spare codes act as plain on and never revert
    write_code(3'd6);
    expect_val(K_OSD, 1, "R6 code 110 on");
    expect_val(K_HL, 0, "R6 code 110 no highlight");
    fields(40);
    expect_val(K_CODE, 6, "R6 code 110 never reverts");
    write_code(3'd7);
    expect_val(K_OSD, 1, "R6 code 111 on");
    expect_val(K_HL, 0, "R6 code 111 no highlight");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule